// File: doc/BRIEF.md
# Pipeline Forwarding and Hazard Unit

This block resolves read-after-write data hazards for a five-stage in-order integer pipeline (fetch, decode/register read, execute, memory, writeback, one clock each). It looks at the register numbers and write enables held in the pipeline registers. From them it produces, for each of the two execute-stage operands, a select code that picks the register-file value, the result waiting in the execute/memory register, or the result in the memory/writeback register. Write-after-read and write-after-write orderings need no action, because instructions issue and retire in order.

A load cannot hand its value to the instruction right behind it. When a load sits in the execute stage and the instruction in decode reads the loaded register, the unit holds the program counter and the fetch/decode register for one cycle and turns the decode/execute entry into a bubble. One cycle later the load has reached writeback's input register, and the ordinary memory/writeback bypass delivers the value. The unit also holds the two-read, one-write register file. The file writes in the first half of the cycle and reads in the second half, so a value being written back is returned to decode in that same cycle, and no extra writeback-to-decode path is needed.

Top module: `hz_pipe_ctrl`

## Requirements
- R1: An operand select is 2'b10 (take the execute/memory result) when mem_wen is 1, mem_rd is nonzero and mem_rd equals that operand's execute-stage source register.
- R2: An operand select is 2'b01 (take the memory/writeback result) when wb_wen is 1, wb_rd is nonzero, wb_rd equals the source register and R1 does not apply.
- R3: When the execute/memory and memory/writeback registers both target an operand's source, the select is 2'b10, so the younger result wins.
- R4: An operand select is 2'b00 (register file) when its source register is 0, or when no stage with its write enable set targets that source. The select is never 2'b11.
- R5: When ex_is_load and ex_wen are 1, ex_rd is nonzero, and ex_rd equals dec_rs1 or dec_rs2, the outputs hold_pc, hold_ifid and bubble_idex are all 1 in that cycle.
- R6: In every other case hold_pc, hold_ifid and bubble_idex are 0. This includes a non-load producer in execute, a load whose destination is register 0, and a load whose destination matches neither decode source.
- R7: When wb_wen is 1 and wb_rd is nonzero, a decode read of wb_rd in the same cycle returns wb_wdata.
- R8: A write with wb_wen=1 to a nonzero register is stored at the clock edge and returned by later reads. Register 0 always reads as zero, even after a write to it.
- R9: After reset, every register reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears the register file |
| dec_rs1 | input | 5 | First source register of the instruction in decode |
| dec_rs2 | input | 5 | Second source register of the instruction in decode |
| ex_rs1 | input | 5 | First source register held in decode/execute |
| ex_rs2 | input | 5 | Second source register held in decode/execute |
| ex_rd | input | 5 | Destination register held in decode/execute |
| ex_wen | input | 1 | Register-write enable held in decode/execute |
| ex_is_load | input | 1 | Memory-read flag held in decode/execute |
| mem_rd | input | 5 | Destination register held in execute/memory |
| mem_wen | input | 1 | Register-write enable held in execute/memory |
| wb_rd | input | 5 | Destination register held in memory/writeback |
| wb_wen | input | 1 | Register-write enable held in memory/writeback |
| wb_wdata | input | 32 | Data being written back |
| dec_rdata1 | output | 32 | Register-file value for dec_rs1 |
| dec_rdata2 | output | 32 | Register-file value for dec_rs2 |
| fwd_a_sel | output | 2 | Bypass select for execute operand A |
| fwd_b_sel | output | 2 | Bypass select for execute operand B |
| hold_pc | output | 1 | Keep the program counter unchanged |
| hold_ifid | output | 1 | Keep the fetch/decode register unchanged |
| bubble_idex | output | 1 | Zero the control signals entering decode/execute |

## Verification
Several functions can fall in the same cycle. A load-use stall can coincide with a bypass select for the instruction already in execute, and with a same-cycle writeback to the very register decode is reading. Double bypass matches on one operand can also collide. To provoke these overlaps, the bench draws register numbers from a range of only four values. A behavioural reference then computes the expected selects, stall lines and read data independently for every cycle and compares all of them. A directed load followed by a dependent instruction is also stepped through stall, bubble and the memory/writeback bypass, to confirm that the stall clears after one cycle.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        FWD_RF  = 2'b00,
        FWD_WB  = 2'b01,
        FWD_MEM = 2'b10
    } fwd_sel_e;
endpackage

// File: rtl/hz_fwd_select.sv
module hz_fwd_select #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] src,
    input  logic [AW-1:0] mem_rd,
    input  logic          mem_wen,
    input  logic [AW-1:0] wb_rd,
    input  logic          wb_wen,
    output logic [1:0]    sel
);
    import hz_pkg::*;

    logic mem_hit, wb_hit;

    always_comb begin
        mem_hit = mem_wen && (mem_rd != '0) && (mem_rd == src);
        wb_hit  = wb_wen  && (wb_rd  != '0) && (wb_rd  == src);
        if (mem_hit)      sel = FWD_MEM;
        else if (wb_hit)  sel = FWD_WB;
        else              sel = FWD_RF;
    end

    // R4
    reg0_never_bypassed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (sel == 2'b00));
    // R4
    sel_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) <= 1);
    // R3
    younger_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && wb_wen && mem_rd == wb_rd && wb_rd == src && src != '0) |-> (sel == 2'b10));
endmodule

// File: rtl/hz_hazard_detect.sv
module hz_hazard_detect #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] dec_rs1,
    input  logic [AW-1:0] dec_rs2,
    input  logic [AW-1:0] ex_rd,
    input  logic          ex_wen,
    input  logic          ex_is_load,
    output logic          stall
);
    logic dst_live;

    always_comb begin
        dst_live = ex_is_load && ex_wen && (ex_rd != '0);
        stall    = dst_live && ((ex_rd == dec_rs1) || (ex_rd == dec_rs2));
    end

    // R6
    no_stall_without_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ex_is_load |-> !stall);
    // R6
    no_stall_on_reg0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_rd == '0) |-> !stall);
endmodule

// File: rtl/hz_regfile.sv
module hz_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    parameter int NRD  = 2,
    localparam int AW  = $clog2(NREG)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NRD-1:0][AW-1:0]   rd_addr,
    output logic [NRD-1:0][XLEN-1:0] rd_data,
    input  logic [AW-1:0]            wr_addr,
    input  logic                     wr_en,
    input  logic [XLEN-1:0]          wr_data
);
    typedef logic [XLEN-1:0] word_t;

    word_t regs_q [NREG];
    word_t regs_d [NREG];

    always_comb begin
        regs_d = regs_q;
        if (wr_en && wr_addr != '0) regs_d[wr_addr] = wr_data;
        regs_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (rd_addr[p] == '0)
                rd_data[p] = '0;
            else if (wr_en && wr_addr == rd_addr[p])
                rd_data[p] = wr_data;
            else
                rd_data[p] = regs_q[rd_addr[p]];
        end

        // R8
        reg0_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_addr[p] == '0) |-> (rd_data[p] == '0));
        // R7
        write_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr != '0 && wr_addr == rd_addr[p]) |-> (rd_data[p] == wr_data));
    end

    // R8
    write_stored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != '0) |=> (regs_q[$past(wr_addr)] == $past(wr_data)));
endmodule

// File: rtl/hz_pipe_ctrl.sv
module hz_pipe_ctrl #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG),
    localparam int NOP = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [AW-1:0]   dec_rs1,
    input  logic [AW-1:0]   dec_rs2,
    input  logic [AW-1:0]   ex_rs1,
    input  logic [AW-1:0]   ex_rs2,
    input  logic [AW-1:0]   ex_rd,
    input  logic            ex_wen,
    input  logic            ex_is_load,
    input  logic [AW-1:0]   mem_rd,
    input  logic            mem_wen,
    input  logic [AW-1:0]   wb_rd,
    input  logic            wb_wen,
    input  logic [XLEN-1:0] wb_wdata,
    output logic [XLEN-1:0] dec_rdata1,
    output logic [XLEN-1:0] dec_rdata2,
    output logic [1:0]      fwd_a_sel,
    output logic [1:0]      fwd_b_sel,
    output logic            hold_pc,
    output logic            hold_ifid,
    output logic            bubble_idex
);
    logic [NOP-1:0][AW-1:0]   dec_src, ex_src;
    logic [NOP-1:0][XLEN-1:0] dec_val;
    logic [NOP-1:0][1:0]      op_sel;
    logic                     ld_stall;

    assign dec_src = {dec_rs2, dec_rs1};
    assign ex_src  = {ex_rs2, ex_rs1};

    hz_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NOP)) rf_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (dec_src),
        .rd_data (dec_val),
        .wr_addr (wb_rd),
        .wr_en   (wb_wen),
        .wr_data (wb_wdata)
    );

    for (genvar k = 0; k < NOP; k++) begin : g_op
        hz_fwd_select #(.AW(AW)) fwd_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .src     (ex_src[k]),
            .mem_rd  (mem_rd),
            .mem_wen (mem_wen),
            .wb_rd   (wb_rd),
            .wb_wen  (wb_wen),
            .sel     (op_sel[k])
        );
    end

    hz_hazard_detect #(.AW(AW)) hz_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .dec_rs1    (dec_rs1),
        .dec_rs2    (dec_rs2),
        .ex_rd      (ex_rd),
        .ex_wen     (ex_wen),
        .ex_is_load (ex_is_load),
        .stall      (ld_stall)
    );

    assign dec_rdata1  = dec_val[0];
    assign dec_rdata2  = dec_val[1];
    assign fwd_a_sel   = op_sel[0];
    assign fwd_b_sel   = op_sel[1];
    assign hold_pc     = ld_stall;
    assign hold_ifid   = ld_stall;
    assign bubble_idex = ld_stall;

    // R5
    load_use_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_is_load && ex_wen && ex_rd != '0 && ex_rd == dec_rs1) |-> (hold_pc && hold_ifid && bubble_idex));
    // R1
    mem_bypass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wen && mem_rd != '0 && mem_rd == ex_rs1) |-> (fwd_a_sel == 2'b10));
endmodule

// File: tb/hz_pipe_ctrl_tb_top.sv
module hz_pipe_ctrl_tb_top;
    localparam int XLEN = 32;
    localparam int NREG = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] dec_rs1 = '0, dec_rs2 = '0, ex_rs1 = '0, ex_rs2 = '0, ex_rd = '0;
    logic [4:0] mem_rd = '0, wb_rd = '0;
    logic ex_wen = 1'b0, ex_is_load = 1'b0, mem_wen = 1'b0, wb_wen = 1'b0;
    logic [31:0] wb_wdata = '0;
    logic [31:0] dec_rdata1, dec_rdata2;
    logic [1:0] fwd_a_sel, fwd_b_sel;
    logic hold_pc, hold_ifid, bubble_idex;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [31:0] model_rf [NREG];

    always #4 clk = ~clk;

    hz_pipe_ctrl #(.XLEN(XLEN), .NREG(NREG)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .dec_rs1(dec_rs1), .dec_rs2(dec_rs2),
        .ex_rs1(ex_rs1), .ex_rs2(ex_rs2), .ex_rd(ex_rd),
        .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_wen(mem_wen),
        .wb_rd(wb_rd), .wb_wen(wb_wen), .wb_wdata(wb_wdata),
        .dec_rdata1(dec_rdata1), .dec_rdata2(dec_rdata2),
        .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel),
        .hold_pc(hold_pc), .hold_ifid(hold_ifid), .bubble_idex(bubble_idex)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] ref_sel(input logic [4:0] s);
        if (s != 0 && mem_wen && mem_rd == s) return 2'b10;
        if (s != 0 && wb_wen && wb_rd == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic string sel_tag(input logic [4:0] s);
        logic mh, wh;
        mh = s != 0 && mem_wen && mem_rd == s;
        wh = s != 0 && wb_wen && wb_rd == s;
        if (mh && wh) return "R3";
        if (mh) return "R1";
        if (wh) return "R2";
        return "R4";
    endfunction

    function automatic logic [31:0] ref_read(input logic [4:0] s);
        if (s == 0) return 32'h0;
        if (wb_wen && wb_rd == s) return wb_wdata;
        return model_rf[s];
    endfunction

    // Compare all outputs against the model; inputs were set before this call.
    task automatic compare_all();
        logic stl;
        string st;
        stl = ex_is_load && ex_wen && ex_rd != 0 && (ex_rd == dec_rs1 || ex_rd == dec_rs2);
        st  = stl ? "R5" : "R6";
        chk(sel_tag(ex_rs1), {30'b0, fwd_a_sel}, {30'b0, ref_sel(ex_rs1)});
        chk(sel_tag(ex_rs2), {30'b0, fwd_b_sel}, {30'b0, ref_sel(ex_rs2)});
        chk(st, {31'b0, hold_pc}, {31'b0, stl});
        chk(st, {31'b0, hold_ifid}, {31'b0, stl});
        chk(st, {31'b0, bubble_idex}, {31'b0, stl});
        chk((wb_wen && wb_rd == dec_rs1 && dec_rs1 != 0) ? "R7" : "R8", dec_rdata1, ref_read(dec_rs1));
        chk((wb_wen && wb_rd == dec_rs2 && dec_rs2 != 0) ? "R7" : "R8", dec_rdata2, ref_read(dec_rs2));
    endtask

    // One cycle: drive at negedge, compare, then the edge commits the write.
    task automatic cycle();
        #1;
        compare_all();
        if (wb_wen && wb_rd != 0) model_rf[wb_rd] = wb_wdata;
        @(negedge clk);
    endtask

    task automatic idle();
        ex_wen = 0; ex_is_load = 0; mem_wen = 0; wb_wen = 0;
        ex_rd = 0; mem_rd = 0; wb_rd = 0; ex_rs1 = 0; ex_rs2 = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NREG; i++) model_rf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: every register reads zero after reset
        for (int r = 0; r < NREG; r += 2) begin
            dec_rs1 = 5'(r); dec_rs2 = 5'(r + 1);
            #1;
            chk("R9", dec_rdata1, 32'h0);
            chk("R9", dec_rdata2, 32'h0);
            @(negedge clk);
        end

        // R8: write to register 0 is discarded
        wb_wen = 1; wb_rd = 0; wb_wdata = 32'hdeadbeef; dec_rs1 = 0; dec_rs2 = 0;
        cycle();
        wb_wen = 0;
        #1; chk("R8", dec_rdata1, 32'h0);
        @(negedge clk);

        // R7 then R8: write-through, then stored value
        wb_wen = 1; wb_rd = 5'd7; wb_wdata = 32'h1234_5678; dec_rs1 = 5'd7; dec_rs2 = 5'd3;
        cycle();
        wb_wen = 0; wb_rd = 0;
        #1; chk("R8", dec_rdata1, 32'h1234_5678);
        @(negedge clk);

        // Load-use sequence: stall, bubble, then memory/writeback bypass
        idle();
        ex_is_load = 1; ex_wen = 1; ex_rd = 5'd5; dec_rs1 = 5'd2; dec_rs2 = 5'd5;
        #1;
        chk("R5", {31'b0, hold_pc}, 32'h1);
        chk("R5", {31'b0, bubble_idex}, 32'h1);
        cycle();
        idle();
        mem_wen = 1; mem_rd = 5'd5;
        #1;
        chk("R6", {31'b0, hold_ifid}, 32'h0);
        cycle();
        idle();
        wb_wen = 1; wb_rd = 5'd5; wb_wdata = 32'h0bad_f00d; ex_rs1 = 5'd2; ex_rs2 = 5'd5;
        #1;
        chk("R2", {30'b0, fwd_b_sel}, 32'h1);
        cycle();

        // R3: both later stages target the same source
        idle();
        mem_wen = 1; mem_rd = 5'd9; wb_wen = 1; wb_rd = 5'd9; wb_wdata = 32'h99;
        ex_rs1 = 5'd9; ex_rs2 = 5'd9;
        #1;
        chk("R3", {30'b0, fwd_a_sel}, 32'h2);
        chk("R3", {30'b0, fwd_b_sel}, 32'h2);
        cycle();

        // R4: enable low means no bypass
        idle();
        mem_rd = 5'd4; wb_rd = 5'd4; ex_rs1 = 5'd4;
        #1;
        chk("R4", {30'b0, fwd_a_sel}, 32'h0);
        cycle();

        // R6: load to register 0 never stalls
        idle();
        ex_is_load = 1; ex_wen = 1; ex_rd = 0; dec_rs1 = 0; dec_rs2 = 0;
        #1;
        chk("R6", {31'b0, hold_pc}, 32'h0);
        cycle();

        // Random overlap phase with a narrow register range
        for (int n = 0; n < 3000; n++) begin
            dec_rs1    = 5'($urandom_range(0, 3));
            dec_rs2    = 5'($urandom_range(0, 3));
            ex_rs1     = 5'($urandom_range(0, 3));
            ex_rs2     = 5'($urandom_range(0, 3));
            ex_rd      = 5'($urandom_range(0, 3));
            mem_rd     = 5'($urandom_range(0, 3));
            wb_rd      = 5'($urandom_range(0, 3));
            ex_wen     = 1'($urandom_range(0, 1));
            ex_is_load = 1'($urandom_range(0, 1));
            mem_wen    = 1'($urandom_range(0, 1));
            wb_wen     = 1'($urandom_range(0, 1));
            wb_wdata   = $urandom;
            cycle();
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule